// File: doc/BRIEF.md
# Colour Lookup Table with Register Loader

This block holds a 256-entry colour lookup table. Each entry carries an 8-bit red, an 8-bit green and an 8-bit blue value. Software loads the table through a 16-byte register window on a 32-bit bus. A write to the index register picks the entry to load. Three writes to the data register then fill that entry's red, green and blue values, in that order. After the blue write, the index moves on to the next entry, so a whole palette can be streamed after a single index write. Both the index and each component are taken from the most significant byte of the bus word.

The pixel pipeline reads the table through a separate port that is always available. It presents an index and gets the packed colour one clock later. Each accepted component write also produces a one-cycle notice that names the entry that changed, so that downstream colour caches can refresh it. Bus reads return zero and change nothing.

Top module: `clut_regfile`

## Requirements
- R1: After a synchronous active-low reset, every entry reads as black (0x000000) except entry 255, which reads as white (0xFFFFFF). `upd_valid` is low.
- R2: An accepted write to offset 0x0 loads the entry index from bits 31:24 of `bus_wdata`.
- R3: Accepted writes to offset 0x4 store bits 31:24 of `bus_wdata` into the current entry's red, then green, then blue component. Bits 23:0 of the word have no effect.
- R4: After the blue write, the index increments modulo 256 (255 wraps to 0) and the next data write goes to red.
- R5: An accepted write to offset 0x0 also returns the component sequence to red, even in the middle of an entry.
- R6: A write is accepted only when all four byte enables `bus_be` are 4'hF and `bus_addr[1:0]` is 0. Any other write changes no entry, no index and no sequence position.
- R7: Writes to offsets 0x8 and 0xC are ignored.
- R8: `bus_rdata` is always zero. A read (`bus_sel` high with `bus_wr` low) at any offset has no effect on the index or the sequence.
- R9: `rd_rgb` presents entry `rd_idx` one clock after `rd_idx` is sampled. Red is in bits 23:16, green in 15:8 and blue in 7:0. A read in the same cycle as a write to that entry returns the value from before the write.
- R10: Each accepted data write raises `upd_valid` for exactly the following cycle, with `upd_idx` set to the entry that was written. `upd_valid` never rises at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access to the register window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always zero) |
| rd_idx | input | 8 | Pixel-side lookup index |
| rd_rgb | output | 24 | Registered colour of the looked-up entry |
| upd_valid | output | 1 | One-cycle notice that an entry changed |
| upd_idx | output | 8 | Entry that changed |

## Verification
The bench attacks the sequence position at its edges:
- It wraps the index from 255 to 0. A design with a missing wrap, or with the increment placed after red instead of blue, writes the wrong entry.
- It rewrites the index in the middle of an entry. A design that does not return to red puts the next byte into green.
- It mixes partial-byte-enable writes, misaligned writes, writes to the unused offsets and reads into a load sequence. A design that lets any of these advance the sequence or store data shifts every later component by one.
- It reads the entry being written in the same cycle, which exposes a read port that forwards the new value or adds a cycle of latency.
- It checks the update notice for its pulse width and its index. A notice that reports the index after the increment names the wrong entry after every blue write.

// File: rtl/clut_pkg.sv
// Shared types for the colour lookup table.
// Assumes the three components are loaded in the fixed order red, green, blue.
package clut_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_t;
endpackage

// File: rtl/clut_bus_decode.sv
// Register window decode.
// Turns a bus access into "index write" and "data write" strobes.
// Assumes the window is one naturally aligned word per register; a write
// with partial byte enables or a misaligned address is dropped.
module clut_bus_decode #(
    parameter int ADDR_W = 4,
    parameter int BE_W   = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    output logic              idx_wr,
    output logic              dat_wr
);
    localparam int WORD_SH = $clog2(BE_W);

    logic full_word;
    logic [ADDR_W-WORD_SH-1:0] word_no;

    // Qualify the access: full word, aligned, write.
    always_comb begin
        full_word = bus_sel && bus_wr && (bus_be == {BE_W{1'b1}})
                    && (bus_addr[WORD_SH-1:0] == '0);
        word_no   = bus_addr[ADDR_W-1:WORD_SH];
        idx_wr    = full_word && (word_no == 0);
        dat_wr    = full_word && (word_no == 1);
    end
endmodule

// File: rtl/clut_seq.sv
// Load sequencer.
// Holds the current entry index and the component phase, steers each data
// write to one component lane, and raises the change notice.
// Assumes the strobes from the decoder are never both high.
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [IDX_W-1:0]  cur_idx,
    output phase_t            cur_phase,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_idx,
    output phase_t            st_lane,
    output logic [COMP_W-1:0] st_data,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_idx
);
    logic unused_low;

    // Only the top bits of the bus word carry meaning.
    assign unused_low = ^wdata[BUS_W-COMP_W-1:0] ^ ^wdata[BUS_W-1:BUS_W-IDX_W];

    // Write port of the store follows the current position.
    always_comb begin
        st_we   = dat_wr;
        st_idx  = cur_idx;
        st_lane = cur_phase;
        st_data = wdata[BUS_W-1 -: COMP_W];
    end

    // Index and phase update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            cur_phase <= PH_RED;
        end else if (idx_wr) begin
            cur_idx   <= wdata[BUS_W-1 -: IDX_W];
            cur_phase <= PH_RED;
        end else if (dat_wr) begin
            case (cur_phase)
                PH_RED:  cur_phase <= PH_GRN;
                PH_GRN:  cur_phase <= PH_BLU;
                default: begin
                    cur_phase <= PH_RED;
                    cur_idx   <= cur_idx + 1'b1;
                end
            endcase
        end
    end

    // One-cycle change notice naming the entry written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_idx   <= '0;
        end else begin
            upd_valid <= dat_wr;
            if (dat_wr) upd_idx <= cur_idx;
        end
    end
endmodule

// File: rtl/clut_store.sv
// Colour table storage.
// One register per entry with per-component write lanes and a registered
// read port. Assumes reset clears all entries to black and sets the last
// entry to white.
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  phase_t              lane,
    input  logic [COMP_W-1:0]   wdata,
    input  logic [IDX_W-1:0]    ridx,
    output logic [3*COMP_W-1:0] rdata
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int RGB_W   = 3 * COMP_W;

    logic [RGB_W-1:0] ent   [ENTRIES];
    logic [RGB_W-1:0] wmask;
    logic [RGB_W-1:0] wval;

    // Build the lane mask for the component being written.
    always_comb begin
        wval = {3{wdata}};
        case (lane)
            PH_RED:  wmask = {{COMP_W{1'b1}}, {(2*COMP_W){1'b0}}};
            PH_GRN:  wmask = {{COMP_W{1'b0}}, {COMP_W{1'b1}}, {COMP_W{1'b0}}};
            default: wmask = {{(2*COMP_W){1'b0}}, {COMP_W{1'b1}}};
        endcase
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam logic [RGB_W-1:0] INIT = (e == ENTRIES - 1) ? {RGB_W{1'b1}} : '0;
        logic [RGB_W-1:0] val_q;

        // Entry register: reset colour, or merge the written component.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= INIT;
            else if (we && (widx == IDX_W'(e)))
                val_q <= (val_q & ~wmask) | (wval & wmask);
        end

        assign ent[e] = val_q;
    end

    // Registered lookup for the pixel pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= ent[ridx];
    end
endmodule

// File: rtl/clut_regfile.sv
// Colour lookup table with register loader (top).
// A 16-byte register window loads a 256-entry RGB table and a registered
// port reads it. Assumes a 32-bit bus. Reads of the window return zero.
module clut_regfile
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W/8-1:0]  bus_be,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [3*COMP_W-1:0] rd_rgb,
    output logic                upd_valid,
    output logic [IDX_W-1:0]    upd_idx
);
    localparam int BE_W = BUS_W / 8;

    logic              idx_wr;
    logic              dat_wr;
    logic [IDX_W-1:0]  cur_idx;
    phase_t            cur_phase;
    logic              st_we;
    logic [IDX_W-1:0]  st_idx;
    phase_t            st_lane;
    logic [COMP_W-1:0] st_data;

    // The window has no readable state.
    assign bus_rdata = '0;

    clut_bus_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr)
    );

    clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .wdata     (bus_wdata),
        .cur_idx   (cur_idx),
        .cur_phase (cur_phase),
        .st_we     (st_we),
        .st_idx    (st_idx),
        .st_lane   (st_lane),
        .st_data   (st_data),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx)
    );

    clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .widx  (st_idx),
        .lane  (st_lane),
        .wdata (st_data),
        .ridx  (rd_idx),
        .rdata (rd_rgb)
    );
endmodule

// File: rtl/clut_regfile_chk.sv
// Property checker for the colour lookup table, bound to the top.
// Relates bus accesses at the ports to the sequencer's index and phase.
module clut_regfile_chk
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 4,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic              upd_valid,
    input logic [IDX_W-1:0]  cur_idx,
    input phase_t            cur_phase
);
    logic good_wr;
    logic dat_acc;
    logic idx_acc;

    // Port-level view of accepted writes.
    always_comb begin
        good_wr = bus_sel && bus_wr && (bus_be == {BE_W{1'b1}});
        idx_acc = good_wr && (bus_addr == ADDR_W'(0));
        dat_acc = good_wr && (bus_addr == ADDR_W'(4));
    end

    a_r3_red_then_green: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && cur_phase == PH_RED) |=> (cur_phase == PH_GRN));

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && cur_phase == PH_BLU && cur_idx == {IDX_W{1'b1}})
        |=> (cur_idx == '0 && cur_phase == PH_RED));

    a_r5_index_write_red: assert property (@(posedge clk) disable iff (!rst_n)
        idx_acc |=> (cur_phase == PH_RED));

    a_r6_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be != {BE_W{1'b1}})
        |=> (!upd_valid && $stable(cur_idx) && $stable(cur_phase)));

    a_r8_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> ($stable(cur_idx) && $stable(cur_phase) && !upd_valid));

    a_r10_notice_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        dat_acc |=> upd_valid);
endmodule

bind clut_regfile clut_regfile_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .BE_W(BUS_W/8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .upd_valid (upd_valid),
    .cur_idx   (cur_idx),
    .cur_phase (cur_phase)
);

// File: tb/test_clut_regfile.sv
module test_clut_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rd_idx = '0;
    logic [23:0] rd_rgb;
    logic        upd_valid;
    logic [7:0]  upd_idx;

    int total = 0;
    int bad = 0;

    // reference model state
    int m_r [256];
    int m_g [256];
    int m_b [256];
    int m_idx = 0;
    int m_ph = 0;
    logic [23:0] e_rgb = '0;
    logic        e_upd = 1'b0;
    logic [7:0]  e_uidx = '0;
    bit          model_live = 1'b0;

    always #5 clk = ~clk;

    clut_regfile i_clut_regfile (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rd_idx(rd_idx), .rd_rgb(rd_rgb),
        .upd_valid(upd_valid), .upd_idx(upd_idx)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                m_r[i] = (i == 255) ? 255 : 0;
                m_g[i] = m_r[i];
                m_b[i] = m_r[i];
            end
            m_idx = 0; m_ph = 0;
            e_rgb = '0; e_upd = 1'b0;
            model_live = 1'b0;
        end else begin
            model_live = 1'b1;
            e_rgb = {m_r[rd_idx][7:0], m_g[rd_idx][7:0], m_b[rd_idx][7:0]};
            e_upd = 1'b0;
            if (bus_sel && bus_wr && bus_be == 4'hF && bus_addr[1:0] == 2'b00) begin
                if (bus_addr[3:2] == 2'd0) begin
                    m_idx = bus_wdata[31:24];
                    m_ph = 0;
                end else if (bus_addr[3:2] == 2'd1) begin
                    if (m_ph == 0) m_r[m_idx] = bus_wdata[31:24];
                    else if (m_ph == 1) m_g[m_idx] = bus_wdata[31:24];
                    else m_b[m_idx] = bus_wdata[31:24];
                    e_upd = 1'b1;
                    e_uidx = m_idx[7:0];
                    if (m_ph == 2) begin
                        m_ph = 0;
                        m_idx = (m_idx + 1) % 256;
                    end else m_ph = m_ph + 1;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_live && rst_n) begin
            check(rd_rgb === e_rgb, "R9 lookup", {8'h0, rd_rgb}, {8'h0, e_rgb});
            check(upd_valid === e_upd, "R10 notice", {31'h0, upd_valid}, {31'h0, e_upd});
            if (e_upd) check(upd_idx === e_uidx, "R10 notice index", {24'h0, upd_idx}, {24'h0, e_uidx});
            check(bus_rdata === 32'h0, "R8 read data", bus_rdata, 32'h0);
        end
    end

    // one bus cycle; called at posedge+1, returns at posedge+1
    task automatic bus(input bit wr, input logic [3:0] a, input logic [3:0] be, input logic [7:0] top);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be;
        bus_wdata = {top, 24'hA5C3E1};
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [7:0] i, input logic [23:0] exp, input string tag);
        rd_idx = i;
        @(posedge clk);
        @(negedge clk);
        check(rd_rgb === exp, tag, {8'h0, rd_rgb}, {8'h0, exp});
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(upd_valid === 1'b0, "R1 notice low", {31'h0, upd_valid}, 32'h0);
        @(posedge clk); #1;
        peek(8'd0,   24'h000000, "R1 entry 0 black");
        peek(8'd128, 24'h000000, "R1 entry 128 black");
        peek(8'd255, 24'hFFFFFF, "R1 entry 255 white");

        // R2/R3: load entry 10
        bus(1, 4'h0, 4'hF, 8'd10);
        bus(1, 4'h4, 4'hF, 8'h11);
        bus(1, 4'h4, 4'hF, 8'h22);
        bus(1, 4'h4, 4'hF, 8'h33);
        peek(8'd10, 24'h112233, "R2 R3 entry 10 loaded");
        // R4: increment to 11
        bus(1, 4'h4, 4'hF, 8'h44);
        bus(1, 4'h4, 4'hF, 8'h55);
        bus(1, 4'h4, 4'hF, 8'h66);
        peek(8'd11, 24'h445566, "R4 auto increment");

        // R4: wrap 255 -> 0
        bus(1, 4'h0, 4'hF, 8'd255);
        bus(1, 4'h4, 4'hF, 8'h01);
        bus(1, 4'h4, 4'hF, 8'h02);
        bus(1, 4'h4, 4'hF, 8'h03);
        bus(1, 4'h4, 4'hF, 8'h77);
        peek(8'd255, 24'h010203, "R4 entry 255");
        peek(8'd0,   24'h770000, "R4 wrap to entry 0");

        // R5: index write mid-entry restarts at red
        bus(1, 4'h0, 4'hF, 8'd20);
        bus(1, 4'h4, 4'hF, 8'hAA);
        bus(1, 4'h4, 4'hF, 8'hBB);
        bus(1, 4'h0, 4'hF, 8'd20);
        bus(1, 4'h4, 4'hF, 8'hCC);
        peek(8'd20, 24'hCCBB00, "R5 phase back to red");

        // R6: partial byte enables and misaligned offsets ignored
        bus(1, 4'h0, 4'hF, 8'd30);
        bus(1, 4'h4, 4'h7, 8'hEE);
        bus(1, 4'h5, 4'hF, 8'hEE);
        bus(1, 4'h1, 4'hF, 8'd40);
        bus(1, 4'h4, 4'hF, 8'h01);
        peek(8'd30, 24'h010000, "R6 bad writes dropped");
        peek(8'd40, 24'h000000, "R6 misaligned index ignored");

        // R7: offsets 8 and C ignored
        bus(1, 4'h8, 4'hF, 8'hDD);
        bus(1, 4'hC, 4'hF, 8'hDD);
        bus(1, 4'h4, 4'hF, 8'h02);
        peek(8'd30, 24'h010200, "R7 unused offsets");

        // R8: reads have no effect and return zero
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h4; bus_be = 4'hF;
        #2 check(bus_rdata === 32'h0, "R8 read zero", bus_rdata, 32'h0);
        @(posedge clk); #1;
        bus(0, 4'h0, 4'hF, 8'h99);
        bus_sel = 1'b0;
        bus(1, 4'h4, 4'hF, 8'h03);
        peek(8'd30, 24'h010203, "R8 reads do not advance");

        // R9: same-cycle read of the entry being written returns old value
        bus(1, 4'h0, 4'hF, 8'd50);
        rd_idx = 8'd50;
        bus(1, 4'h4, 4'hF, 8'h5E);
        @(negedge clk);
        check(rd_rgb === 24'h000000, "R9 old value on collision", {8'h0, rd_rgb}, 32'h0);
        @(posedge clk); @(negedge clk);
        check(rd_rgb === 24'h5E0000, "R9 new value next", {8'h0, rd_rgb}, 32'h5E0000);

        // R10: back-to-back notices
        @(posedge clk); #1;
        bus(1, 4'h4, 4'hF, 8'h10);
        @(negedge clk);
        check(upd_valid === 1'b1 && upd_idx === 8'd50, "R10 notice index 50", {23'h0, upd_valid, upd_idx}, {23'h0, 1'b1, 8'd50});
        @(posedge clk); @(negedge clk);
        check(upd_valid === 1'b0, "R10 single pulse", {31'h0, upd_valid}, 32'h0);

        // reset again restores defaults (R1)
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        peek(8'd10, 24'h000000, "R1 reset clears entry");
        peek(8'd255, 24'hFFFFFF, "R1 reset white");

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule